// File: doc/BRIEF.md
# Compressed Push-Multiple Sequencer

This block carries out a 16-bit stack-frame push. The instruction names a group of registers to save and a stack adjustment. The group is always the return-address register plus a run of saved registers starting at s0. The block takes the list code and the adjustment immediate when `start` is pulsed. It then issues one word store per listed register over a valid/ready store port. Each store takes its data from a combinational register-file read port. When every store has been accepted, the block writes the lowered stack pointer in a single cycle.

Each store address is taken from a copy of the stack pointer captured when the instruction is accepted. A fault elsewhere in the memory path can raise `abort` while stores are in progress. The sequence then starts again from the first store, and the stack pointer is still written exactly once, after the whole sequence has completed. Fetch, full instruction decode, the memory system and the matching pop variants are handled by neighbouring blocks.

Top module: `push_seq`

## Requirements
- R1: `rlist` values 4 to 15 select the register set. Value 4 is ra alone. Each value from 5 to 14 adds one more saved register, so 5 gives ra and s0, and 14 gives ra and s0-s9. Value 15 gives ra and s0-s11, so 13 stores in all. One store is issued per listed register.
- R2: `rlist` values 0 to 3 are reserved. A start with such a value raises `illegal` for exactly the following cycle and issues no store. It leaves `busy` low and writes no stack pointer.
- R3: The frame size is the register count times 4, rounded up to a multiple of 16, plus `spimm` times 16. The stack-pointer write carries the old sp minus this frame size. For example, ra with s0-s5 and `spimm`=2 lowers sp by 64.
- R4: Store k (counting from 0) goes to address old_sp − 4·(k+1). The highest listed saved register is stored first, and ra is stored last, at the lowest address.
- R5: `st_reg` carries the architectural index of the register being stored: 1 for ra, 8 and 9 for s0 and s1, and 18 to 27 for s2 to s11. `rf_raddr` equals `st_reg`, and `st_data` carries the returned `rf_rdata`.
- R6: While `st_valid` is high and `st_ready` is low, `st_valid`, `st_addr`, `st_reg` and `st_data` hold their values.
- R7: `sp_we` pulses for exactly one cycle per push. It comes in the cycle after the last store is accepted, and never before all stores of the current pass are accepted.
- R8: `busy` rises in the cycle after acceptance and stays high up to and including the `sp_we` cycle. A `start` seen while busy is ignored.
- R9: Store addresses and the written stack pointer depend only on the `sp_in` value sampled at acceptance. Later changes to `sp_in` have no effect.
- R10: `abort` during the store phase restarts the sequence at store 0 and discards any acceptance in that cycle. `abort` while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction present; accepted when not busy |
| rlist | input | 4 | Register-list code |
| spimm | input | 2 | Extra stack adjustment in 16-byte units |
| sp_in | input | 32 | Current stack pointer value |
| busy | output | 1 | Push in progress |
| illegal | output | 1 | Reserved list code seen (one-cycle pulse) |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| st_valid | output | 1 | Store request valid |
| st_ready | input | 1 | Store request accepted |
| st_addr | output | 32 | Store byte address |
| st_data | output | 32 | Store data |
| st_reg | output | 5 | Index of the register being stored |
| abort | input | 1 | Fault replay: restart stores from the first |
| sp_we | output | 1 | Stack-pointer write strobe |
| sp_wdata | output | 32 | New stack pointer |

## Verification
The bench exercises the smallest list, the largest list, and the list just below the largest, each paired with a different immediate. This catches a decoder that handles the jump from s9 to s11 wrongly, because it would store 12 registers or write a frame that is not 16-byte aligned. Back-pressure on the store port and a `sp_in` that moves during the sequence expose designs that advance without a handshake or that read the live stack pointer. An abort in the middle of the sequence checks that the replay starts again at the top address and that the stack pointer is written once, not twice. A reserved code, a start issued while busy, and an abort while idle must each leave the outputs untouched.

// File: rtl/push_seq_pkg.sv
package push_seq_pkg;
    localparam int XLEN        = 32;
    localparam int WORD_BYTES  = XLEN / 8;
    localparam int RIDX_W      = 5;
    localparam int RLIST_W     = 4;
    localparam int SPIMM_W     = 2;
    localparam int MAX_REGS    = 13;
    localparam int CNT_W       = $clog2(MAX_REGS + 1);
    localparam int FRAME_ALIGN = 16;
    localparam int SPIMM_UNIT  = 16;
    localparam int RLIST_MIN   = 4;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_STORE  = 2'd1,
        PS_COMMIT = 2'd2
    } push_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] nregs;
        logic [XLEN-1:0]  frame;
    } push_frame_t;

    typedef struct packed {
        logic [XLEN-1:0]   addr;
        logic [RIDX_W-1:0] ridx;
    } store_req_t;

    // Registers covered by a list code; the top code skips to s11.
    function automatic logic [CNT_W-1:0] rlist_count(input logic [RLIST_W-1:0] code);
        if (code < RLIST_W'(RLIST_MIN))
            return '0;
        else if (code == {RLIST_W{1'b1}})
            return CNT_W'(MAX_REGS);
        else
            return CNT_W'(code - RLIST_W'(RLIST_MIN - 1));
    endfunction

    // Position 0 is ra; position j>0 is saved register j-1.
    function automatic logic [RIDX_W-1:0] slot_to_ridx(input logic [CNT_W-1:0] pos);
        if (pos == '0)
            return RIDX_W'(1);
        else if (pos < CNT_W'(3))
            return RIDX_W'(pos) + RIDX_W'(7);
        else
            return RIDX_W'(pos) + RIDX_W'(15);
    endfunction

    function automatic logic [XLEN-1:0] frame_bytes(input logic [CNT_W-1:0] n,
                                                    input logic [SPIMM_W-1:0] imm);
        logic [XLEN-1:0] raw;
        logic [XLEN-1:0] rounded;
        raw     = XLEN'(n) * XLEN'(WORD_BYTES);
        rounded = (raw + XLEN'(FRAME_ALIGN - 1)) & ~XLEN'(FRAME_ALIGN - 1);
        return rounded + XLEN'(imm) * XLEN'(SPIMM_UNIT);
    endfunction
endpackage

// File: rtl/push_decode.sv
module push_decode
    import push_seq_pkg::*;
(
    input  logic [RLIST_W-1:0] rlist,
    input  logic [SPIMM_W-1:0] spimm,
    output logic               legal,
    output push_frame_t        frm
);
    logic [CNT_W-1:0] n;

    always_comb begin
        n         = rlist_count(rlist);
        legal     = (n != '0);
        frm.nregs = n;
        frm.frame = frame_bytes(n, spimm);
    end
endmodule

// File: rtl/push_addr_gen.sv
module push_addr_gen
    import push_seq_pkg::*;
(
    input  logic [XLEN-1:0]  sp_base,
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] nregs,
    output store_req_t       req
);
    logic [CNT_W-1:0] pos;
    logic [XLEN-1:0]  offset;

    always_comb begin
        pos      = nregs - idx - CNT_W'(1);
        offset   = (XLEN'(idx) + XLEN'(1)) * XLEN'(WORD_BYTES);
        req.addr = sp_base - offset;
        req.ridx = slot_to_ridx(pos);
    end
endmodule

// File: rtl/push_ctrl.sv
module push_ctrl
    import push_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             legal,
    input  push_frame_t      frm,
    input  logic [XLEN-1:0]  sp_in,
    input  logic             st_ready,
    input  logic             abort,
    output logic             busy,
    output logic             illegal,
    output logic             st_valid,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_wdata,
    output logic [XLEN-1:0]  sp_base,
    output logic [CNT_W-1:0] idx,
    output logic [CNT_W-1:0] nregs
);
    push_state_e     state;
    logic [XLEN-1:0] frame_q;
    logic            last_store;

    assign last_store = (idx == nregs - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_IDLE;
            idx     <= '0;
            nregs   <= '0;
            frame_q <= '0;
            sp_base <= '0;
            illegal <= 1'b0;
        end else begin
            illegal <= 1'b0;
            unique case (state)
                PS_IDLE: begin
                    if (start) begin
                        if (legal) begin
                            state   <= PS_STORE;
                            idx     <= '0;
                            nregs   <= frm.nregs;
                            frame_q <= frm.frame;
                            sp_base <= sp_in;
                        end else begin
                            illegal <= 1'b1;
                        end
                    end
                end
                PS_STORE: begin
                    if (abort) begin
                        idx <= '0;
                    end else if (st_ready) begin
                        if (last_store)
                            state <= PS_COMMIT;
                        else
                            idx <= idx + CNT_W'(1);
                    end
                end
                PS_COMMIT: state <= PS_IDLE;
                default:   state <= PS_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (state != PS_IDLE);
        st_valid = (state == PS_STORE);
        sp_we    = (state == PS_COMMIT);
        sp_wdata = sp_base - frame_q;
    end

    assert_illegal_idle_R2: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !busy);

    assert_frame_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && legal) |-> (frm.frame[3:0] == 4'd0 && frm.nregs != '0));

    assert_sp_write_once_R7: assert property (@(posedge clk) disable iff (rst)
        sp_we |=> !sp_we);

    assert_commit_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
        sp_we |-> $past(st_valid && st_ready && !abort));

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && legal) |=> busy);

    assert_abort_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (st_valid && abort) |=> (st_valid && idx == '0));
endmodule

// File: rtl/push_seq.sv
module push_seq
    import push_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [RLIST_W-1:0]  rlist,
    input  logic [SPIMM_W-1:0]  spimm,
    input  logic [XLEN-1:0]     sp_in,
    output logic                busy,
    output logic                illegal,
    output logic [RIDX_W-1:0]   rf_raddr,
    input  logic [XLEN-1:0]     rf_rdata,
    output logic                st_valid,
    input  logic                st_ready,
    output logic [XLEN-1:0]     st_addr,
    output logic [XLEN-1:0]     st_data,
    output logic [RIDX_W-1:0]   st_reg,
    input  logic                abort,
    output logic                sp_we,
    output logic [XLEN-1:0]     sp_wdata
);
    logic             legal;
    push_frame_t      frm;
    logic [XLEN-1:0]  sp_base;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] nregs;
    store_req_t       req;

    push_decode u_decode (
        .rlist (rlist),
        .spimm (spimm),
        .legal (legal),
        .frm   (frm)
    );

    push_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .legal    (legal),
        .frm      (frm),
        .sp_in    (sp_in),
        .st_ready (st_ready),
        .abort    (abort),
        .busy     (busy),
        .illegal  (illegal),
        .st_valid (st_valid),
        .sp_we    (sp_we),
        .sp_wdata (sp_wdata),
        .sp_base  (sp_base),
        .idx      (idx),
        .nregs    (nregs)
    );

    push_addr_gen u_addr (
        .sp_base (sp_base),
        .idx     (idx),
        .nregs   (nregs),
        .req     (req)
    );

    assign st_addr  = req.addr;
    assign st_reg   = req.ridx;
    assign rf_raddr = req.ridx;
    assign st_data  = rf_rdata;

    assert_store_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready && !abort) |=>
            (st_valid && $stable(st_addr) && $stable(st_reg)));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!st_valid && !sp_we));

    assert_ra_last_R4: assert property (@(posedge clk) disable iff (rst)
        sp_we |-> $past(st_reg == RIDX_W'(1)));
endmodule

// File: tb/tb_push_seq.sv
module tb_push_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [3:0]  rlist;
    logic [1:0]  spimm;
    logic [31:0] sp_in;
    logic        busy, illegal;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        st_valid, st_ready;
    logic [31:0] st_addr, st_data;
    logic [4:0]  st_reg;
    logic        abort;
    logic        sp_we;
    logic [31:0] sp_wdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] rf_value(input logic [4:0] r);
        return 32'h5A00_0000 | (32'(r) * 32'h0001_0101);
    endfunction

    assign rf_rdata = rf_value(rf_raddr);

    push_seq dut (
        .clk(clk), .rst(rst), .start(start), .rlist(rlist), .spimm(spimm),
        .sp_in(sp_in), .busy(busy), .illegal(illegal), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_reg(st_reg), .abort(abort),
        .sp_we(sp_we), .sp_wdata(sp_wdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int exp_count(input logic [3:0] rl);
        return (rl == 4'd15) ? 13 : int'(rl) - 3;
    endfunction

    function automatic logic [4:0] exp_reg(input int pos);
        if (pos == 0) return 5'd1;
        if (pos <= 2) return 5'(7 + pos);
        return 5'(15 + pos);
    endfunction

    function automatic logic [31:0] exp_frame(input int n, input logic [1:0] imm);
        return 32'(((n * 4 + 15) / 16) * 16 + int'(imm) * 16);
    endfunction

    task automatic do_push(input string name, input logic [3:0] rl, input logic [1:0] imm,
                           input logic [31:0] sp, input bit stall, input int abort_at,
                           input bit poke);
        int n = exp_count(rl);
        logic [31:0] a [0:15];
        logic [4:0]  r [0:15];
        logic [31:0] d [0:15];
        int ns = 0;
        int commits = 0;
        bit early = 0;
        bit aborted = 0;
        bit order_ok = 1;
        bit reg_ok = 1;
        bit data_ok = 1;
        logic [31:0] sp_seen = '0;
        @(negedge clk);
        start = 1'b1; rlist = rl; spimm = imm; sp_in = sp;
        @(negedge clk);
        start = 1'b0; sp_in = ~sp;
        chk(busy === 1'b1, "R8", {name, " busy after accept"}, 32'(busy), 32'd1);
        for (int c = 0; c < 300; c++) begin
            st_ready = 1'b0; abort = 1'b0; start = 1'b0;
            if (sp_we) begin
                commits++;
                sp_seen = sp_wdata;
                if (ns != n) early = 1;
            end
            if (!busy) break;
            if (poke && c == 1) begin
                start = 1'b1; rlist = 4'd15; spimm = 2'd3; sp_in = 32'h1234_5670;
            end
            if (st_valid) begin
                if (!aborted && abort_at >= 0 && ns == abort_at) begin
                    abort = 1'b1; st_ready = 1'b1; aborted = 1; ns = 0;
                end else if (!stall || (c % 3) == 2) begin
                    st_ready = 1'b1;
                    if (ns < 16) begin a[ns] = st_addr; r[ns] = st_reg; d[ns] = st_data; end
                    ns++;
                end
            end
            @(negedge clk);
        end
        st_ready = 1'b0; abort = 1'b0; start = 1'b0;
        chk(ns == n, "R1", {name, " store count"}, 32'(ns), 32'(n));
        for (int k = 0; k < n && k < 16; k++) begin
            if (a[k] !== sp - 32'(4 * (k + 1))) order_ok = 0;
            if (r[k] !== exp_reg(n - 1 - k)) reg_ok = 0;
            if (d[k] !== rf_value(exp_reg(n - 1 - k))) data_ok = 0;
        end
        chk(order_ok, "R4 R9", {name, " store addresses from latched sp"}, a[0], sp - 32'd4);
        chk(reg_ok, "R5", {name, " register order, ra last"}, 32'(r[n-1]), 32'd1);
        chk(data_ok, "R5", {name, " store data from register read"}, d[0],
            rf_value(exp_reg(n - 1)));
        chk(commits == 1 && !early, (abort_at >= 0) ? "R10" : "R7",
            {name, " single sp write after all stores"}, 32'(commits), 32'd1);
        chk(sp_seen === sp - exp_frame(n, imm), "R3", {name, " new sp"},
            sp_seen, sp - exp_frame(n, imm));
        chk(busy === 1'b0 && sp_we === 1'b0, "R8", {name, " idle after sp write"},
            32'({busy, sp_we}), 32'd0);
    endtask

    task automatic test_reset();
        chk(busy === 1'b0 && st_valid === 1'b0 && sp_we === 1'b0 && illegal === 1'b0,
            "R8", "reset state", 32'({busy, st_valid, sp_we, illegal}), 32'd0);
    endtask

    task automatic test_reserved();
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            start = 1'b1; rlist = 4'(v); spimm = 2'd1; sp_in = 32'h0000_4000;
            @(negedge clk);
            start = 1'b0;
            chk(illegal === 1'b1 && busy === 1'b0 && st_valid === 1'b0, "R2",
                "reserved code flags illegal", 32'({illegal, busy, st_valid}), 32'b100);
            @(negedge clk);
            chk(illegal === 1'b0 && sp_we === 1'b0 && st_valid === 1'b0, "R2",
                "illegal is one cycle, no side effect", 32'({illegal, sp_we, st_valid}), 32'd0);
        end
    endtask

    task automatic test_idle_abort();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(busy === 1'b0 && st_valid === 1'b0 && sp_we === 1'b0, "R10",
            "abort while idle ignored", 32'({busy, st_valid, sp_we}), 32'd0);
    endtask

    task automatic test_hold();
        @(negedge clk);
        start = 1'b1; rlist = 4'd6; spimm = 2'd0; sp_in = 32'h0000_2000;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(st_valid === 1'b1 && st_addr === 32'h0000_1FFC && st_reg === 5'd9, "R6",
                "request held under back-pressure", st_addr, 32'h0000_1FFC);
        end
        do_finish_hold();
    endtask

    task automatic do_finish_hold();
        for (int c = 0; c < 20 && busy; c++) begin
            st_ready = st_valid;
            @(negedge clk);
        end
        st_ready = 1'b0;
    endtask

    initial begin
        start = 0; rlist = 0; spimm = 0; sp_in = 0; st_ready = 0; abort = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        do_push("ra only", 4'd4, 2'd0, 32'h0001_0000, 0, -1, 0);
        do_push("ra s0-s5", 4'd10, 2'd2, 32'h0000_8000, 0, -1, 0);
        do_push("ra s0-s11 stalled", 4'd15, 2'd3, 32'h8000_1000, 1, -1, 0);
        do_push("ra s0-s9", 4'd14, 2'd1, 32'h0000_3FF0, 0, -1, 0);
        do_push("abort mid", 4'd12, 2'd0, 32'h0002_0000, 1, 3, 0);
        do_push("start while busy", 4'd7, 2'd2, 32'h0000_9000, 0, -1, 1);
        test_reserved();
        test_idle_abort();
        test_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule